// File: doc/BRIEF.md
# Configurable Port with Interrupt Modes

This block controls an eight-position parallel port of which four positions are built: bits 7, 2, 1 and 0. Software reaches it through a small register bus. Through that bus it reads the synchronized pin levels, sets which pins drive, supplies output data, picks a function for each pin and clears captured edge events. The pins at positions 7, 2 and 1 can also serve as active-low interrupt request inputs, either latched on a falling edge or following the level. The block passes requests to an external interrupt controller. It does not arbitrate between them.

Every pin input goes through a two-stage synchronizer. An edge is defined as a difference between two consecutive synchronized samples. A separate 3-bit priority input belongs to the pin at position 1. When that input is all zeros, the pin becomes a bus-error input and overrides its mode field. The direction bit of a pin only reaches the output enable while the pin is in a digital I/O function.

Top module: `pio_irq_port`

Registers are selected by `reg_addr_i`:
- 0: pin state, read only.
- 1: direction.
- 2: mode fields.
- 3: output data.
- 4: edge flags.
- Any other address reads zero.

## Requirements
- R1: A read of address 0 returns the synchronized pin state at bits 7, 2, 1 and 0, whatever the direction bits hold. All other bits read 0.
- R2: A write to address 0 changes no register and no output.
- R3: Direction bit p (address 1, bit p) set to 1 enables output p, as long as pin p is in a digital I/O function. Only bits 7, 2, 1 and 0 are stored; the rest read 0. The register resets to 0.
- R4: Address 2 holds a 2-bit mode field for pin p at bits [2p+1:2p]. Fields for unbuilt positions read 0. At reset, the fields of pins 7, 2 and 1 are 11. The field of pin 0 resets to 00 when `mux_cfg_i` is 1 and to 11 otherwise.
- R5: Mode 01 sets flag p (address 4, bit p) on a rising edge, and mode 10 sets it on a falling edge. A flag stays set until a 1 is written to its bit. If a new edge arrives in the same cycle as that clearing write, the flag stays set.
- R6: Mode 00 on pins 7, 2 and 1 latches `irq_req_o[p]` on a falling edge. The request stays latched until a cycle with `irq_ack_i[p]` high and no new falling edge. The output enable of the pin is held off.
- R7: Mode 11 on pins 7, 2 and 1 drives `irq_req_o[p]` to the inverse of the synchronized pin level. The output enable of the pin is held off.
- R8: Pin 0 treats modes 00 and 11 as plain digital I/O. Its output enable follows its direction bit, and it raises no request and no flag.
- R9: While `berr_level_i` is 000, `bus_err_o` is the inverse of the synchronized level of pin 1. Pin 1 then raises no request and no flag, and its output enable is off. For any other level, `bus_err_o` is 0.
- R10: The output data register (address 3, bits 7, 2, 1 and 0) resets to 0 and drives `pad_out_o`.
- R11: A pin change shows at address 0 after two clock edges. The flag or latched request it causes appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mux_cfg_i | input | 1 | Selects the reset value of the pin 0 mode field |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| pad_i | input | 8 | Pin input levels |
| pad_out_o | output | 8 | Pin output levels |
| pad_oe_o | output | 8 | Pin output enables |
| irq_ack_i | input | 8 | Clears a latched request, one bit per pin |
| irq_req_o | output | 8 | Interrupt requests, one bit per pin |
| berr_level_i | input | 3 | Priority level for pin 1; 000 selects bus error |
| bus_err_o | output | 1 | Bus-error indication |

## Verification
The hardest case to reach is a clearing write that lands on the exact cycle a new edge sets the same flag. The edge must be launched at the pins three edges before the write strobe. The stimulus places that write two cycles after the pin change, so the two events collide inside the flag register. A second hard case is moving pin 1 into bus-error duty while it still has an edge mode. The bench toggles pin 1 with the level input at zero and checks that the bus-error output follows the pin, while no flag and no request appear. A reference model runs alongside and compares every output on every clock.

// File: rtl/pio_irq_pkg.sv
package pio_irq_pkg;
  typedef enum logic [1:0] {
    MODE_IRQ_EDGE  = 2'b00,
    MODE_RISE      = 2'b01,
    MODE_FALL      = 2'b10,
    MODE_IRQ_LEVEL = 2'b11
  } pin_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PIN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOUT = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs import pio_irq_pkg::*; #(
  parameter int              PORT_W    = 8,
  parameter int              DATA_W    = 16,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'h87
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mux_cfg_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [PORT_W-1:0]   dir_o,
  output logic [PORT_W-1:0]   dout_o,
  output logic [2*PORT_W-1:0] mode_o
);
  localparam int MODE_W = 2 * PORT_W;

  function automatic logic [MODE_W-1:0] field_mask(input logic [PORT_W-1:0] m);
    logic [MODE_W-1:0] r;
    r = '0;
    for (int p = 0; p < PORT_W; p++) if (m[p]) r[2*p +: 2] = 2'b11;
    return r;
  endfunction

  localparam logic [MODE_W-1:0] MODE_MASK = field_mask(IMPL_MASK);

  logic [MODE_W-1:0] mode_rst;
  assign mode_rst = MODE_MASK & ~(mux_cfg_i ? MODE_W'(2'b11) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      dout_o <= '0;
      mode_o <= mode_rst;
    end else if (we_i) begin
      unique case (addr_i)
        A_DIR:   dir_o  <= wdata_i[PORT_W-1:0] & IMPL_MASK;
        A_DOUT:  dout_o <= wdata_i[PORT_W-1:0] & IMPL_MASK;
        A_MODE:  mode_o <= wdata_i[MODE_W-1:0] & MODE_MASK;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pio_event.sv
module pio_event import pio_irq_pkg::*; #(
  parameter int                PORT_W    = 8,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'h87,
  parameter logic [PORT_W-1:0] IRQ_MASK  = 8'h86,
  parameter int                BERR_PIN  = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PORT_W-1:0]   cur_i,
  input  logic [2*PORT_W-1:0] mode_i,
  input  logic                berr_en_i,
  input  logic [PORT_W-1:0]   flag_clr_i,
  input  logic [PORT_W-1:0]   ack_i,
  output logic [PORT_W-1:0]   flag_o,
  output logic [PORT_W-1:0]   irq_o,
  output logic [PORT_W-1:0]   oe_allow_o
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    localparam bit IS_IMPL = IMPL_MASK[i];
    localparam bit IS_IRQ  = IRQ_MASK[i];
    localparam bit IS_BERR = (i == BERR_PIN);

    pin_mode_e m;
    logic prev_q, flag_q, latch_q;
    logic rise, fall, berr, hit, irq_edge, irq_lvl;

    assign m        = pin_mode_e'(mode_i[2*i +: 2]);
    assign rise     = cur_i[i] & ~prev_q;
    assign fall     = prev_q & ~cur_i[i];
    assign berr     = IS_BERR && berr_en_i;
    assign hit      = IS_IMPL && !berr &&
                      ((m == MODE_RISE && rise) || (m == MODE_FALL && fall));
    assign irq_edge = IS_IRQ && !berr && (m == MODE_IRQ_EDGE);
    assign irq_lvl  = IS_IRQ && !berr && (m == MODE_IRQ_LEVEL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q  <= 1'b1;
        flag_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q  <= cur_i[i];
        flag_q  <= hit | (flag_q & ~flag_clr_i[i]);   // new edge wins over clear
        latch_q <= irq_edge & (fall | (latch_q & ~ack_i[i]));
      end
    end

    assign flag_o[i]     = flag_q & IS_IMPL;
    assign irq_o[i]      = irq_edge ? latch_q : (irq_lvl & ~cur_i[i]);
    assign oe_allow_o[i] = IS_IMPL && !(irq_edge || irq_lvl || berr);
  end
endmodule

// File: rtl/pio_irq_port.sv
module pio_irq_port import pio_irq_pkg::*; #(
  parameter int                PORT_W    = 8,
  parameter int                DATA_W    = 16,
  parameter int                LVL_W     = 3,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'h87,
  parameter logic [PORT_W-1:0] IRQ_MASK  = 8'h86,
  parameter int                BERR_PIN  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mux_cfg_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [PORT_W-1:0] pad_i,
  output logic [PORT_W-1:0] pad_out_o,
  output logic [PORT_W-1:0] pad_oe_o,
  input  logic [PORT_W-1:0] irq_ack_i,
  output logic [PORT_W-1:0] irq_req_o,
  input  logic [LVL_W-1:0]  berr_level_i,
  output logic              bus_err_o
);
  logic [PORT_W-1:0]   pin_sync, dir, dout, flags, flag_clr, oe_allow;
  logic [2*PORT_W-1:0] mode;
  logic                berr_en;

  assign berr_en  = (berr_level_i == '0);
  assign flag_clr = (reg_we_i && reg_addr_i == A_FLAG) ? reg_wdata_i[PORT_W-1:0] : '0;

  pio_sync #(.W(PORT_W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(pin_sync)
  );

  pio_regs #(.PORT_W(PORT_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .mux_cfg_i(mux_cfg_i),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .dir_o(dir), .dout_o(dout), .mode_o(mode)
  );

  pio_event #(.PORT_W(PORT_W), .IMPL_MASK(IMPL_MASK), .IRQ_MASK(IRQ_MASK),
              .BERR_PIN(BERR_PIN)) u_event (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(pin_sync), .mode_i(mode),
    .berr_en_i(berr_en), .flag_clr_i(flag_clr), .ack_i(irq_ack_i),
    .flag_o(flags), .irq_o(irq_req_o), .oe_allow_o(oe_allow)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_PIN:   reg_rdata_o = DATA_W'(pin_sync & IMPL_MASK);
      A_DIR:   reg_rdata_o = DATA_W'(dir);
      A_MODE:  reg_rdata_o = DATA_W'(mode);
      A_DOUT:  reg_rdata_o = DATA_W'(dout);
      A_FLAG:  reg_rdata_o = DATA_W'(flags);
      default: reg_rdata_o = '0;
    endcase
  end

  assign pad_out_o = dout;
  assign pad_oe_o  = dir & oe_allow;
  assign bus_err_o = berr_en & ~pin_sync[BERR_PIN];
endmodule

// File: rtl/pio_irq_port_chk.sv
module pio_irq_port_chk import pio_irq_pkg::*; #(
  parameter int                PORT_W    = 8,
  parameter int                DATA_W    = 16,
  parameter int                LVL_W     = 3,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'h87,
  parameter logic [PORT_W-1:0] IRQ_MASK  = 8'h86,
  parameter int                BERR_PIN  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [PORT_W-1:0] pad_i,
  input logic [PORT_W-1:0] pad_oe_o,
  input logic [PORT_W-1:0] irq_req_o,
  input logic [LVL_W-1:0]  berr_level_i,
  input logic              bus_err_o,
  input logic [PORT_W-1:0] dir,
  input logic [PORT_W-1:0] flags,
  input logic [PORT_W-1:0] flag_clr
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_pin_sync_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && reg_addr_i == A_PIN) |->
      reg_rdata_o == DATA_W'($past(pad_i, 2) & IMPL_MASK));

  assert_oe_from_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~(dir & IMPL_MASK)) == '0);

  assert_irq_no_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o & pad_oe_o) == '0);

  assert_irq_pins_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o & ~IRQ_MASK) == '0);

  assert_berr_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (berr_level_i == '0) |-> (!irq_req_o[BERR_PIN] && !pad_oe_o[BERR_PIN]));

  assert_berr_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (berr_level_i != '0) |-> !bus_err_o);

  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flags) & ~$past(flag_clr)) & ~flags) == '0);
endmodule

bind pio_irq_port pio_irq_port_chk #(
  .PORT_W(PORT_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
  .IMPL_MASK(IMPL_MASK), .IRQ_MASK(IRQ_MASK), .BERR_PIN(BERR_PIN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .pad_i(pad_i), .pad_oe_o(pad_oe_o),
  .irq_req_o(irq_req_o), .berr_level_i(berr_level_i), .bus_err_o(bus_err_o),
  .dir(dir), .flags(flags), .flag_clr(flag_clr)
);

// File: tb/sim_pio_irq_port.sv
`timescale 1ns/100ps
module sim_pio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mux = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  pad = 8'hFF;
  logic [7:0]  pout, poe, ack = '0, irq;
  logic [2:0]  lvl = 3'd5;
  logic        berr;

  int checks = 0, errors = 0;
  string phase = "R4";
  int rd_sel = 0;

  always #2.5 clk = ~clk;

  pio_irq_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .mux_cfg_i(mux), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pad_i(pad), .pad_out_o(pout), .pad_oe_o(poe), .irq_ack_i(ack),
    .irq_req_o(irq), .berr_level_i(lvl), .bus_err_o(berr)
  );

  // reference model
  localparam logic [7:0] BUILT = 8'h87;
  localparam logic [7:0] REQ_PINS = 8'h86;
  logic [7:0]  m_s1, m_s2, m_prev, m_dir, m_dout, m_flag, m_latch;
  logic [15:0] m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 8'hFF; m_s2 = 8'hFF; m_prev = 8'hFF;
      m_dir = 0; m_dout = 0; m_flag = 0; m_latch = 0;
      m_mode = mux ? 16'hC03C : 16'hC03F;
    end else begin
      logic [7:0] nf, nl;
      nf = 0; nl = 0;
      for (int i = 0; i < 8; i++) begin
        int md;
        bit cur, p, bus, hit, clr, edge_req;
        md = int'(m_mode[2*i +: 2]);
        cur = m_s2[i]; p = m_prev[i];
        bus = (i == 1) && (lvl == 0);
        hit = BUILT[i] && !bus && ((md == 1 && !p && cur) || (md == 2 && p && !cur));
        clr = we && addr == 3'd4 && wdata[i];
        nf[i] = hit || (m_flag[i] && !clr);
        edge_req = REQ_PINS[i] && !bus && md == 0;
        nl[i] = edge_req && ((p && !cur) || (m_latch[i] && !ack[i]));
      end
      m_flag = nf; m_latch = nl;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad;
      if (we) begin
        case (addr)
          3'd1: m_dir  = wdata[7:0] & BUILT;
          3'd2: m_mode = wdata & 16'hC03F;
          3'd3: m_dout = wdata[7:0] & BUILT;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] exp_rd();
    case (addr)
      3'd0: return {8'h0, m_s2 & BUILT};
      3'd1: return {8'h0, m_dir};
      3'd2: return m_mode;
      3'd3: return {8'h0, m_dout};
      3'd4: return {8'h0, m_flag};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [7:0] exp_oe();
    logic [7:0] r;
    r = 0;
    for (int i = 0; i < 8; i++) begin
      int md;
      bit bus, req_mode;
      md = int'(m_mode[2*i +: 2]);
      bus = (i == 1) && (lvl == 0);
      req_mode = REQ_PINS[i] && (md == 0 || md == 3);
      r[i] = BUILT[i] && m_dir[i] && !bus && !req_mode;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_irq();
    logic [7:0] r;
    r = 0;
    for (int i = 0; i < 8; i++) begin
      int md;
      md = int'(m_mode[2*i +: 2]);
      if (REQ_PINS[i] && !((i == 1) && (lvl == 0))) begin
        if (md == 0) r[i] = m_latch[i];
        else if (md == 3) r[i] = !m_s2[i];
      end
    end
    return r;
  endfunction

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("rdata", rdata, exp_rd());
    chk("oe", {8'h0, poe}, {8'h0, exp_oe()});
    chk("out", {8'h0, pout}, {8'h0, m_dout});
    chk("irq", {8'h0, irq}, {8'h0, exp_irq()});
    chk("berr", {15'h0, berr}, {15'h0, (lvl == 0) && !m_s2[1]});
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      addr = 3'(rd_sel);
      rd_sel = (rd_sel + 1) % 6;
      tick();
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic do_reset(logic m);
    mux = m; rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    phase = "R4";  do_reset(1'b1); idle(6);
    phase = "R8";  wr(3'd1, 16'hFFFF); idle(6);
    phase = "R10"; wr(3'd3, 16'h00A5); idle(6);
    phase = "R2";  wr(3'd0, 16'hFFFF); idle(6);
    phase = "R11"; pad = 8'h00; addr = 3'd0; tick(); tick(); tick(); idle(4);
    pad = 8'hFF; idle(6);
    phase = "R7";  pad = 8'h7B; idle(6); pad = 8'hFF; idle(4);
    phase = "R3";  wr(3'd2, 16'h4026); wr(3'd1, 16'h00F5); idle(6);
    phase = "R5";  pad = 8'h00; idle(5); pad = 8'hFF; idle(5);
    wr(3'd4, 16'h0004); idle(4); wr(3'd4, 16'hFFFF); idle(4);
    pad = 8'h00; addr = 3'd4; tick(); tick(); wr(3'd4, 16'hFFFF); idle(5);
    wr(3'd4, 16'hFFFF); idle(3);
    phase = "R6";  wr(3'd2, 16'h0000); pad = 8'hFF; idle(4);
    pad = 8'h00; idle(4); pad = 8'hFF; idle(3);
    ack = 8'h04; tick(); ack = 8'h00; idle(3);
    ack = 8'hFF; tick(); ack = 8'h00; idle(3);
    phase = "R9";  lvl = 3'd0; pad = 8'hFD; idle(4); pad = 8'hFF; idle(4);
    wr(3'd2, 16'h0004); pad = 8'hFD; idle(4); pad = 8'hFF; idle(4);
    lvl = 3'd3; idle(4);
    phase = "R4";  do_reset(1'b0); idle(6);
    phase = "R1";  wr(3'd1, 16'h00FF); wr(3'd2, 16'h4016); pad = 8'h81; idle(6);
    pad = 8'h06; idle(6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule